// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block turns an asynchronous serial line into characters. A 16x oversampling enable paces the sampling. A falling edge on the idle line arms the receiver. The line is checked again half a bit later, and a pulse that has gone back high by then is dropped. Otherwise the receiver reads 5 to 8 data bits, an optional parity bit and one stop bit, each at the middle of its bit cell. The character is stored together with its parity, framing and break flags.

Characters go into a 16-entry receive queue. When queueing is switched off, the queue acts as a single holding register. Sticky line-status flags report overrun, parity error, framing error and break until the status is read. A live flag shows whether any stored character carries an error. A trigger output rises once the fill level reaches a programmable threshold. A bus front end reads characters with one pop pulse and reads the status with another.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, `fill_level` is 0, and `data_ready`, `overrun`, `parity_err`, `frame_err`, `break_det`, `fifo_has_err` and `trig_reached` are all 0.
- R2: A low level on `rx_in` that is high again at the mid-bit check (8 ticks after the falling edge is seen) produces no character. The receiver goes back to waiting for a start edge.
- R3: A frame is a low start bit, then `word_len` data bits LSB first (codes 00, 01, 10, 11 give 5, 6, 7, 8 bits), an optional parity bit and a stop bit. The oldest stored character appears on `rx_char`, with the bits above the word length read as 0.
- R4: When `par_en` is 1, `parity_err` is set if the received parity bit differs from the expected one. The expected bit is the XOR of the data bits when `par_even`=1 and its inverse when `par_even`=0. When `par_stick`=1 it is instead fixed at the inverse of `par_even`. When `par_en` is 0 no parity bit is expected and no parity error is raised.
- R5: A stop bit sampled low sets `frame_err`. The receiver then looks for the next start edge at once, so a following good frame is received correctly.
- R6: If the line stays low through start, data, parity and stop, a single character of value 0 is stored with its break and framing flags set, and `break_det` and `frame_err` are raised. No further character is accepted until the line has returned high.
- R7: With `fifo_en`=1, a character that completes while 16 characters are stored and no pop occurs in that cycle is dropped. `overrun` is set and the stored characters and their order are unchanged.
- R8: With `fifo_en`=0 the store holds one character. A new character that arrives while it is occupied, with no pop in that cycle, replaces it and sets `overrun`.
- R9: `fill_level` counts the stored characters and `data_ready` is 1 exactly while it is nonzero. A `rd_pop` pulse removes the oldest character, so `data_ready` clears after the last one is popped.
- R10: `overrun`, `parity_err`, `frame_err` and `break_det` stay set until a `rd_status` pulse clears them. A new event in the same cycle wins over the clear.
- R11: With `fifo_en`=1, `fifo_has_err` is 1 while at least one stored character carries a parity, framing or break flag. With `fifo_en`=0 it is 0.
- R12: With `fifo_en`=1, `trig_reached` is 1 while `fill_level` is at least 1, 4, 8 or 14 for `trig_sel` codes 00, 01, 10, 11. With `fifo_en`=0 it is 0.
- R13: A `fifo_clr` pulse, or any change of `fifo_en`, empties the store in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Serial line, synchronous to clk, idle high |
| word_len | input | 2 | Data bits per character: 00=5 through 11=8 |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| par_stick | input | 1 | Parity bit fixed at the inverse of par_even |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| trig_sel | input | 2 | Trigger threshold code: 1, 4, 8, 14 entries |
| fifo_clr | input | 1 | Pulse: empty the receive store |
| rd_pop | input | 1 | Pulse: remove the oldest character |
| rd_status | input | 1 | Pulse: clear the sticky line flags |
| rx_char | output | 8 | Oldest stored character, 0 when empty |
| data_ready | output | 1 | At least one character stored |
| overrun | output | 1 | Sticky: character lost or replaced |
| parity_err | output | 1 | Sticky: parity mismatch on a stored character |
| frame_err | output | 1 | Sticky: stop bit sampled low |
| break_det | output | 1 | Sticky: line held low for a whole character |
| fifo_has_err | output | 1 | An errored character is currently stored |
| trig_reached | output | 1 | Fill level at or above the threshold |
| fill_level | output | 5 | Number of stored characters |

## Verification
A tick counter off by one moves the sample point away from mid-bit. This corrupts `rx_char` or `frame_err` on the very first frame, because the bench holds each bit for exactly 16 ticks. A read or write pointer that goes wrong shows up at the next pop as characters in the wrong order, which is why the bench fills all 16 entries and drains them. A drifting error count is silent until the last errored entry leaves. It then shows as `fifo_has_err` that is stuck high or drops too early. The bench compares that flag after every push and every pop.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

    // One received character with its error tags
    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } srx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HOLD
    } srx_state_t;

    // Index of the final data bit: 5 bits -> 4 ... 8 bits -> 7
    function automatic logic [2:0] last_bit_idx(input logic [1:0] wlen);
        return {1'b1, wlen};
    endfunction

    // Parity bit the transmitter should have sent (data already masked)
    function automatic logic parity_ref(input logic [7:0] d,
                                        input logic       even,
                                        input logic       stick);
        if (stick)
            return ~even;
        return (^d) ^ ~even;
    endfunction

    // Fill threshold selected by the trigger code
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/srx_deser.sv
`timescale 1ns/1ps
module srx_deser
    import srx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       done,
    output srx_entry_t ent
);
    localparam int unsigned   CW   = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    srx_state_t    state;
    logic [CW-1:0] tcnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          par_bit;
    logic          all_low;
    logic          brk_now;

    assign brk_now = all_low && !rxd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            all_low <= 1'b0;
            done    <= 1'b0;
            ent     <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (!rxd) begin
                            state <= S_START;
                            tcnt  <= '0;
                        end
                    end
                    S_START: begin
                        if (tcnt == MID) begin
                            tcnt <= '0;
                            if (rxd) begin
                                state <= S_IDLE;          // false start
                            end else begin
                                state   <= S_DATA;
                                bidx    <= '0;
                                shreg   <= '0;
                                all_low <= 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_DATA, S_PAR, S_STOP: begin
                        if (tcnt != LAST) begin
                            tcnt <= tcnt + 1'b1;
                        end else begin
                            tcnt <= '0;
                            if (state == S_DATA) begin
                                shreg[bidx] <= rxd;
                                all_low     <= all_low & ~rxd;
                                if (bidx == last_bit_idx(wlen))
                                    state <= par_en ? S_PAR : S_STOP;
                                else
                                    bidx <= bidx + 1'b1;
                            end else if (state == S_PAR) begin
                                par_bit <= rxd;
                                all_low <= all_low & ~rxd;
                                state   <= S_STOP;
                            end else begin
                                done      <= 1'b1;
                                ent.data  <= shreg;
                                ent.brk   <= brk_now;
                                ent.ferr  <= ~rxd;
                                ent.perr  <= par_en && !brk_now &&
                                             (par_bit != parity_ref(shreg, par_even, par_stick));
                                state     <= brk_now ? S_HOLD : S_IDLE;
                            end
                        end
                    end
                    S_HOLD: begin
                        if (rxd)
                            state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/srx_rxfifo.sv
`timescale 1ns/1ps
module srx_rxfifo
    import srx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         fifo_mode,
    input  logic                         push,
    input  logic                         pop,
    input  srx_entry_t                   wr_ent,
    output logic [7:0]                   head_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         accepted,
    output logic                         overflow,
    output logic                         err_any
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    srx_entry_t    mem [DEPTH];
    srx_entry_t    head;
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] errcnt;
    logic          full, do_pop, do_push, do_repl, in_err, hd_err;

    assign head      = mem[rp];
    assign head_data = head.data;
    assign full      = fifo_mode ? (count == CW'(DEPTH)) : (count != '0);
    assign do_pop    = pop && (count != '0);
    assign do_push   = push && (!full || do_pop);
    assign do_repl   = push && full && !do_pop && !fifo_mode;
    assign accepted  = do_push || do_repl;
    assign overflow  = push && full && !do_pop;
    assign in_err    = wr_ent.perr | wr_ent.ferr | wr_ent.brk;
    assign hd_err    = head.perr | head.ferr | head.brk;
    assign err_any   = (errcnt != '0);

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wp] <= wr_ent;
        else if (do_repl)
            mem[rp] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp     <= '0;
            rp     <= '0;
            count  <= '0;
            errcnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count  <= count + CW'(do_push) - CW'(do_pop);
            errcnt <= errcnt + CW'(do_push && in_err) + CW'(do_repl && in_err)
                             - CW'(do_pop && hd_err) - CW'(do_repl && hd_err);
        end
    end

endmodule

// File: rtl/serial_rx_status.sv
`timescale 1ns/1ps
module serial_rx_status
    import srx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned OVS   = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick16,
    input  logic                       rx_in,
    input  logic [1:0]                 word_len,
    input  logic                       par_en,
    input  logic                       par_even,
    input  logic                       par_stick,
    input  logic                       fifo_en,
    input  logic [1:0]                 trig_sel,
    input  logic                       fifo_clr,
    input  logic                       rd_pop,
    input  logic                       rd_status,
    output logic [7:0]                 rx_char,
    output logic                       data_ready,
    output logic                       overrun,
    output logic                       parity_err,
    output logic                       frame_err,
    output logic                       break_det,
    output logic                       fifo_has_err,
    output logic                       trig_reached,
    output logic [$clog2(DEPTH+1)-1:0] fill_level
);
    srx_entry_t rx_ent;
    logic [7:0] head_data;
    logic       rx_done, acc, ovf, err_any, mode_q, flush;

    srx_deser #(.OVS(OVS)) u_deser (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .rxd       (rx_in),
        .wlen      (word_len),
        .par_en    (par_en),
        .par_even  (par_even),
        .par_stick (par_stick),
        .done      (rx_done),
        .ent       (rx_ent)
    );

    // Mode switch flushes the store, as does an explicit clear
    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= fifo_en;
    end
    assign flush = fifo_clr || (fifo_en != mode_q);

    srx_rxfifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush),
        .fifo_mode (fifo_en),
        .push      (rx_done),
        .pop       (rd_pop),
        .wr_ent    (rx_ent),
        .head_data (head_data),
        .count     (fill_level),
        .accepted  (acc),
        .overflow  (ovf),
        .err_any   (err_any)
    );

    // Sticky line flags: a new event wins over a status read
    always_ff @(posedge clk) begin
        if (rst) begin
            overrun    <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            break_det  <= 1'b0;
        end else begin
            overrun    <= (overrun    && !rd_status) || ovf;
            parity_err <= (parity_err && !rd_status) || (acc && rx_ent.perr);
            frame_err  <= (frame_err  && !rd_status) || (acc && rx_ent.ferr);
            break_det  <= (break_det  && !rd_status) || (acc && rx_ent.brk);
        end
    end

    assign data_ready   = (fill_level != '0);
    assign rx_char      = data_ready ? head_data : 8'h00;
    assign fifo_has_err = fifo_en && err_any;
    assign trig_reached = fifo_en && (32'(fill_level) >= trig_level(trig_sel));

endmodule

// File: rtl/serial_rx_status_chk.sv
`timescale 1ns/1ps
module serial_rx_status_chk #(
    parameter int unsigned DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       fifo_en,
    input logic                       fifo_clr,
    input logic                       rd_status,
    input logic                       data_ready,
    input logic                       overrun,
    input logic                       parity_err,
    input logic                       frame_err,
    input logic                       break_det,
    input logic                       fifo_has_err,
    input logic                       trig_reached,
    input logic [$clog2(DEPTH+1)-1:0] fill_level
);
    a_r13_clear_empties: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (fill_level == '0));

    a_r7_fill_bounded: assert property (@(posedge clk) disable iff (rst)
        32'(fill_level) <= DEPTH);

    a_r8_hold_single: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && $past(!fifo_en)) |-> (fill_level <= 1));

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun && !rd_status) |=> overrun);

    a_r10_parity_sticky: assert property (@(posedge clk) disable iff (rst)
        (parity_err && !rd_status) |=> parity_err);

    a_r6_break_framing: assert property (@(posedge clk) disable iff (rst)
        $rose(break_det) |-> frame_err);

    a_r11_err_needs_data: assert property (@(posedge clk) disable iff (rst)
        fifo_has_err |-> data_ready);

    a_r12_trig_needs_data: assert property (@(posedge clk) disable iff (rst)
        trig_reached |-> data_ready);

endmodule

bind serial_rx_status serial_rx_status_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fifo_en      (fifo_en),
    .fifo_clr     (fifo_clr),
    .rd_status    (rd_status),
    .data_ready   (data_ready),
    .overrun      (overrun),
    .parity_err   (parity_err),
    .frame_err    (frame_err),
    .break_det    (break_det),
    .fifo_has_err (fifo_has_err),
    .trig_reached (trig_reached),
    .fill_level   (fill_level)
);

// File: tb/serial_rx_status_tb.sv
`timescale 1ns/1ps
module serial_rx_status_tb;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16;
    logic       rx_in = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
    logic       fifo_en = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       fifo_clr = 1'b0, rd_pop = 1'b0, rd_status = 1'b0;
    logic [7:0] rx_char;
    logic       data_ready, overrun, parity_err, frame_err, break_det;
    logic       fifo_has_err, trig_reached;
    logic [4:0] fill_level;
    logic [1:0] tdiv;

    int  nchk = 0;
    int  nerr = 0;
    bit  finished = 0;

    logic [10:0] mq[$];      // {data, perr, ferr, brk}
    logic        m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            tdiv   <= 2'd0;
            tick16 <= 1'b0;
        end else begin
            tdiv   <= tdiv + 2'd1;
            tick16 <= (tdiv == 2'd3);
        end
    end

    serial_rx_status u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
        .word_len(word_len), .par_en(par_en), .par_even(par_even),
        .par_stick(par_stick), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .fifo_clr(fifo_clr), .rd_pop(rd_pop), .rd_status(rd_status),
        .rx_char(rx_char), .data_ready(data_ready), .overrun(overrun),
        .parity_err(parity_err), .frame_err(frame_err), .break_det(break_det),
        .fifo_has_err(fifo_has_err), .trig_reached(trig_reached),
        .fill_level(fill_level)
    );

    // ---------------- bench model functions ----------------
    function automatic int lvl(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] wmask(input logic [1:0] wl);
        return 8'hFF >> (3 - int'(wl));
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic ev, input logic st);
        if (st) return ~ev;
        return (^d) ^ ~ev;
    endfunction

    function automatic bit any_err();
        foreach (mq[i]) if (mq[i][2:0] != 3'b000) return 1;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_push(input logic [10:0] e);
        if (fifo_en) begin
            if (mq.size() < DEPTH) begin
                mq.push_back(e);
                m_pe |= e[2]; m_fe |= e[1]; m_bi |= e[0];
            end else begin
                m_oe = 1;
            end
        end else begin
            if (mq.size() == 0) mq.push_back(e);
            else begin mq[0] = e; m_oe = 1; end
            m_pe |= e[2]; m_fe |= e[1]; m_bi |= e[0];
        end
    endtask

    task automatic check_all();
        check("R9 fill", int'(fill_level), mq.size());
        check("R9 ready", int'(data_ready), int'(mq.size() != 0));
        if (mq.size() != 0) check("R3 char", int'(rx_char), int'(mq[0][10:3]));
        check("R4 parity flag", int'(parity_err), int'(m_pe));
        check("R5 framing flag", int'(frame_err), int'(m_fe));
        check("R6 break flag", int'(break_det), int'(m_bi));
        check("R10 overrun flag", int'(overrun), int'(m_oe));
        check("R11 err-in-store", int'(fifo_has_err), int'(fifo_en && any_err()));
        check("R12 trigger", int'(trig_reached), int'(fifo_en && mq.size() >= lvl(trig_sel)));
    endtask

    // ---------------- stimulus tasks ----------------
    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
    endtask

    task automatic put_bit(input logic v);
        #1 rx_in = v;
        wait_ticks(16);
    endtask

    task automatic pulse_pop();
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
        if (mq.size() != 0) void'(mq.pop_front());
    endtask

    task automatic pulse_status();
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
        m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
    endtask

    task automatic pulse_clear();
        @(negedge clk) fifo_clr = 1'b1;
        @(negedge clk) fifo_clr = 1'b0;
        mq.delete();
    endtask

    // Sends one frame and updates the model; checks happen after return
    task automatic send_frame(input logic [7:0] d, input logic [1:0] wl,
                              input logic pen, input logic ev, input logic st,
                              input logic badp, input logic bads);
        logic [7:0] md;
        md = d & wmask(wl);
        @(negedge clk);
        word_len = wl; par_en = pen; par_even = ev; par_stick = st;
        put_bit(1'b0);
        for (int i = 0; i < 5 + int'(wl); i++) put_bit(md[i]);
        if (pen) put_bit(exp_par(md, ev, st) ^ badp);
        put_bit(~bads);
        put_bit(1'b1);
        @(negedge clk);
        model_push({md, pen & badp, bads, 1'b0});
    endtask

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd4242));
        repeat (6) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 fill", int'(fill_level), 0);
        check("R1 ready", int'(data_ready), 0);
        check("R1 flags", int'({overrun, parity_err, frame_err, break_det}), 0);
        check("R1 err/trig", int'({fifo_has_err, trig_reached}), 0);

        fifo_en = 1'b1;
        repeat (3) @(negedge clk);

        // Random frames mixed with pops and status reads
        for (int n = 0; n < 30; n++) begin
            logic [7:0] d;
            logic [1:0] wl;
            logic pen, ev, st, bp, bs;
            d   = 8'($urandom);
            wl  = 2'($urandom_range(0, 3));
            pen = 1'($urandom_range(0, 1));
            ev  = 1'($urandom_range(0, 1));
            st  = ($urandom_range(0, 4) == 0);
            bp  = pen && ($urandom_range(0, 4) == 0);
            bs  = ($urandom_range(0, 5) == 0);
            if (bs) d[0] = 1'b1;           // keep it from looking like a break
            trig_sel = 2'($urandom_range(0, 3));
            send_frame(d, wl, pen, ev, st, bp, bs);
            check_all();
            if ($urandom_range(0, 9) < 6) begin pulse_pop(); check_all(); end
            if ($urandom_range(0, 1) == 1) begin pulse_status(); check_all(); end
        end

        // R13: explicit clear
        pulse_clear();
        check("R13 clear fill", int'(fill_level), 0);
        check("R13 clear ready", int'(data_ready), 0);
        pulse_status();

        // R2: short low pulse is not a character
        #1 rx_in = 1'b0;
        wait_ticks(5);
        #1 rx_in = 1'b1;
        wait_ticks(48);
        @(negedge clk);
        check("R2 false start", int'(fill_level), 0);
        send_frame(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all();
        pulse_pop();

        // R6: break, then no new character while the line stays low
        word_len = 2'd3; par_en = 1'b0;
        for (int i = 0; i < 14; i++) put_bit(1'b0);
        @(negedge clk);
        model_push({8'h00, 1'b0, 1'b1, 1'b1});
        check("R6 single entry", int'(fill_level), 1);
        check("R6 break set", int'(break_det), 1);
        check_all();
        for (int i = 0; i < 14; i++) put_bit(1'b0);
        @(negedge clk);
        check("R6 no retrigger", int'(fill_level), 1);
        put_bit(1'b1);
        send_frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 resumes", int'(fill_level), 2);
        check_all();
        pulse_clear();
        pulse_status();

        // R7 / R11 / R12: fill to capacity and overflow once
        for (int i = 0; i < 17; i++) begin
            trig_sel = 2'(i % 4);
            send_frame(8'(8'h30 + i), 2'd3, 1'b1, 1'b1, 1'b0, (i == 3), 1'b0);
            check_all();
        end
        check("R7 overrun", int'(overrun), 1);
        check("R7 stays full", int'(fill_level), 16);
        check("R11 err held", int'(fifo_has_err), 1);
        for (int i = 0; i < 16; i++) begin
            check("R7 order", int'(rx_char), 8'h30 + i);
            pulse_pop();
            check_all();
        end
        pulse_status();

        // R13: mode change empties the store
        send_frame(8'h11, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'h22, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all();
        @(negedge clk) fifo_en = 1'b0;
        repeat (2) @(negedge clk);
        mq.delete();
        check("R13 mode change", int'(fill_level), 0);

        // R8: single holding register
        send_frame(8'h5A, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check_all();
        check("R11 off in holding mode", int'(fifo_has_err), 0);
        send_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all();
        check("R8 replaced", int'(rx_char), 8'hA5);
        check("R8 overrun", int'(overrun), 1);
        check("R8 one entry", int'(fill_level), 1);
        pulse_pop();
        check("R9 empty after last pop", int'(data_ready), 0);

        // R10: flags survive a clean frame, clear on a status read
        send_frame(8'h7E, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all();
        check("R10 still set", int'(overrun), 1);
        pulse_status();
        check("R10 cleared", int'({overrun, parity_err, frame_err, break_det}), 0);
        check_all();

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
            $finish;
        end
    end

endmodule